// File: doc/BRIEF.md
# PAL Raster Timing Generator with Vertical-Blank Status

This block produces the frame timing of a 50 Hz raster display from one master clock. It has two independent dividers. One divides the master clock by 5 to give a pixel-clock enable. The other divides it by 16 to give a CPU-cycle enable, so each CPU cycle holds 3.2 pixel periods.

A raster counter walks through a fixed frame of 312 lines of 341 pixels, which is 106392 pixels. That equals 33247.5 CPU cycles. Frame length never changes. Because the frame holds half a CPU cycle, the CPU cycle in which each frame starts alternates in parity over a four-frame period.

A vertical-blank flag is held in a two-state machine with these states and transitions:
- `VB_OFF` goes to `VB_ON` on the frame-start pixel, unless a qualified status read lands in the same master clock.
- `VB_ON` goes to `VB_OFF` on a qualified status read.
- `VB_ON` also goes to `VB_OFF` at the auto-clear pixel late in blanking.

The CPU side sees the flag in bit 7 of a status port, and reading that port clears the flag. An interrupt request follows the flag while an enable is set. The start phases of both dividers are loaded at reset, and so is the choice of auto-clear pixel. A bench can therefore cover every alignment between the pixel grid and the CPU grid.

Top module: `pal_frame_timer`

## Requirements
- R1: `pix_ce_o` is high in the master clock after t edges since reset release exactly when (pix_phase_i + t) mod PIX_DIV equals PIX_DIV-1. `cpu_ce_o` is high exactly when (cpu_phase_i + t) mod CPU_DIV equals CPU_DIV-1. The phase inputs are sampled while reset is low.
- R2: During and right after reset, the position shows the last pixel of the frame: x = PIX_PER_LINE-1 and y = LINES-1. Each master clock with `pix_ce_o` high moves one pixel forward. x runs from 0 to PIX_PER_LINE-1 and then y steps by one. After the last pixel the position wraps to pixel 0 of line 0. A frame is always LINES*PIX_PER_LINE pixels.
- R3: After each frame start, `frame_par_o` holds the parity of the CPU cycle in which pixel 0 began. The count is of CPU cycles since reset release, with 0 meaning even.
- R4: The flag (`vbl_o`) becomes 1 on the edge that moves the position to pixel 0.
- R5: The flag clears by itself on the edge that moves the position to frame pixel CLR_PIX. If `clr_early_i` was 1 during reset, this happens one pixel earlier, at CLR_PIX-1.
- R6: `stat_o[7]` shows the flag. It also reads 1 in a clock in which the flag is being set. `stat_o[6:0]` is always 0. A clock with `rd_i` and `cpu_ce_o` both high is a qualified read, and it leaves the flag 0 after the edge, even when it coincides with the frame start.
- R7: `rd_i` in a clock where `cpu_ce_o` is low has no effect on the flag.
- R8: `nmi_o` is 1 exactly when the flag is 1 and `nmi_en_i` is 1.
- R9: `frame_cnt_o` starts at 0 and increases by one (modulo 2^FCW) at each frame start.
- R10: When the frame length is 8 modulo 16 in master-clock units, as with the defaults, the start parity repeats with a period of four frames. From phases 0/0 the sequence is even, odd, odd, even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | synchronous active-low reset |
| pix_phase_i | input | PPW | initial pixel-divider count, sampled in reset |
| cpu_phase_i | input | CPW | initial CPU-divider count, sampled in reset |
| clr_early_i | input | 1 | selects the earlier auto-clear pixel, sampled in reset |
| nmi_en_i | input | 1 | interrupt enable |
| rd_i | input | 1 | status read strobe |
| stat_o | output | 8 | status byte, flag in bit 7 |
| pix_ce_o | output | 1 | pixel-clock enable |
| cpu_ce_o | output | 1 | CPU-cycle enable |
| pix_x_o | output | XW | pixel in line |
| line_y_o | output | YW | line in frame |
| vbl_o | output | 1 | vertical-blank flag |
| nmi_o | output | 1 | interrupt request |
| frame_par_o | output | 1 | parity of the CPU cycle holding the last frame start |
| frame_cnt_o | output | FCW | frame starts since reset |

## Verification
The free-running raster is run from several pairs of divider phases. Comparing the enables, position, flag, parity and frame count against closed-form values shows whether the two dividers stay independent. It also shows whether the phase loading shifts each one correctly.

Both auto-clear options are run, which separates the two clear pixels. A phase pair chosen so that a CPU edge, a pixel edge and the frame start all fall in the same master clock exercises the coincident read-and-set case. Reads placed on and off CPU enables inside blanking show that the read clear is gated, and that a read flag stays clear through the auto-clear point.

// File: rtl/pal_timing_pkg.sv
package pal_timing_pkg;
    typedef enum logic {
        VB_OFF = 1'b0,
        VB_ON  = 1'b1
    } vb_state_e;
endpackage

// File: rtl/pal_clk_div.sv
module pal_clk_div #(
    parameter int DIV = 5,
    parameter int W   = $clog2(DIV)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] phase_i,
    output logic         ce_o
);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // the phase is taken while reset is held; out-of-range values start at zero
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= (32'(phase_i) < DIV) ? phase_i : '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ce_o = (cnt_q == LAST);
endmodule

// File: rtl/pal_raster_cnt.sv
module pal_raster_cnt #(
    parameter int PIX   = 341,
    parameter int LINES = 312,
    parameter int XW    = $clog2(PIX),
    parameter int YW    = $clog2(LINES),
    parameter int IW    = $clog2(PIX * LINES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);
    localparam int            NPIX   = PIX * LINES;
    localparam logic [XW-1:0] X_LAST = XW'(PIX - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(LINES - 1);
    localparam logic [IW-1:0] I_LAST = IW'(NPIX - 1);

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [IW-1:0] idx_q;

    // reset parks on the final pixel so the first advance opens a frame
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            x_q   <= X_LAST;
            y_q   <= Y_LAST;
            idx_q <= I_LAST;
        end else if (adv_i) begin
            if (idx_q == I_LAST) begin
                x_q   <= '0;
                y_q   <= '0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (x_q == X_LAST) begin
                    x_q <= '0;
                    y_q <= y_q + 1'b1;
                end else begin
                    x_q <= x_q + 1'b1;
                end
            end
        end
    end

    assign x_o    = x_q;
    assign y_o    = y_q;
    assign idx_o  = idx_q;
    assign last_o = (idx_q == I_LAST);
endmodule

// File: rtl/pal_vbl_fsm.sv
module pal_vbl_fsm
    import pal_timing_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic rd_i,
    output logic flag_o,
    output logic peek_o
);
    vb_state_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= VB_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // a qualified read wins over a frame start in the same clock
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            VB_OFF: if (set_i && !rd_i)  st_d = VB_ON;
            VB_ON:  if (rd_i || clr_i)   st_d = VB_OFF;
            default:                     st_d = VB_OFF;
        endcase
    end

    always_comb begin
        flag_o = (st_q == VB_ON);
        peek_o = (st_q == VB_ON) || set_i;
    end
endmodule

// File: rtl/pal_frame_timer.sv
module pal_frame_timer #(
    parameter int PIX_PER_LINE = 341,
    parameter int LINES        = 312,
    parameter int PIX_DIV      = 5,
    parameter int CPU_DIV      = 16,
    parameter int CLR_PIX      = 23869,
    parameter int FCW          = 16,
    parameter int XW           = $clog2(PIX_PER_LINE),
    parameter int YW           = $clog2(LINES),
    parameter int PPW          = $clog2(PIX_DIV),
    parameter int CPW          = $clog2(CPU_DIV)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PPW-1:0]  pix_phase_i,
    input  logic [CPW-1:0]  cpu_phase_i,
    input  logic            clr_early_i,
    input  logic            nmi_en_i,
    input  logic            rd_i,
    output logic [7:0]      stat_o,
    output logic            pix_ce_o,
    output logic            cpu_ce_o,
    output logic [XW-1:0]   pix_x_o,
    output logic [YW-1:0]   line_y_o,
    output logic            vbl_o,
    output logic            nmi_o,
    output logic            frame_par_o,
    output logic [FCW-1:0]  frame_cnt_o
);
    localparam int            FRAME_PIX = PIX_PER_LINE * LINES;
    localparam int            IW        = $clog2(FRAME_PIX);
    localparam logic [IW-1:0] PRE_LATE  = IW'(CLR_PIX - 1);
    localparam logic [IW-1:0] PRE_EARLY = IW'(CLR_PIX - 2);

    logic          pix_ce, cpu_ce;
    logic [IW-1:0] idx;
    logic          last;
    logic          set_ev, clr_ev, rd_ev;
    logic          flag, peek;
    logic [IW-1:0] clr_pre_q;
    logic          cyc_par_q, frame_par_q;
    logic [FCW-1:0] frame_cnt_q;

    pal_clk_div #(.DIV(PIX_DIV), .W(PPW)) u_pix_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (pix_phase_i),
        .ce_o    (pix_ce)
    );

    pal_clk_div #(.DIV(CPU_DIV), .W(CPW)) u_cpu_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (cpu_phase_i),
        .ce_o    (cpu_ce)
    );

    pal_raster_cnt #(
        .PIX(PIX_PER_LINE), .LINES(LINES), .XW(XW), .YW(YW), .IW(IW)
    ) u_raster (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (pix_ce),
        .x_o    (pix_x_o),
        .y_o    (line_y_o),
        .idx_o  (idx),
        .last_o (last)
    );

    assign set_ev = pix_ce && last;
    assign clr_ev = pix_ce && (idx == clr_pre_q);
    assign rd_ev  = rd_i && cpu_ce;

    pal_vbl_fsm u_vbl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_ev),
        .clr_i  (clr_ev),
        .rd_i   (rd_ev),
        .flag_o (flag),
        .peek_o (peek)
    );

    // clear point, CPU-cycle parity and frame bookkeeping
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            clr_pre_q   <= clr_early_i ? PRE_EARLY : PRE_LATE;
            cyc_par_q   <= 1'b0;
            frame_par_q <= 1'b0;
            frame_cnt_q <= '0;
        end else begin
            if (cpu_ce) begin
                cyc_par_q <= ~cyc_par_q;
            end
            if (set_ev) begin
                frame_par_q <= cyc_par_q ^ cpu_ce;
                frame_cnt_q <= frame_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        stat_o      = {peek, 7'b0};
        pix_ce_o    = pix_ce;
        cpu_ce_o    = cpu_ce;
        vbl_o       = flag;
        nmi_o       = flag && nmi_en_i;
        frame_par_o = frame_par_q;
        frame_cnt_o = frame_cnt_q;
    end
endmodule

// File: rtl/pal_frame_timer_chk.sv
module pal_frame_timer_chk #(
    parameter int PIX   = 341,
    parameter int LINES = 312,
    parameter int XW    = 9,
    parameter int YW    = 9,
    parameter int FCW   = 16
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           nmi_en_i,
    input logic           rd_i,
    input logic [7:0]     stat_o,
    input logic           pix_ce_o,
    input logic           cpu_ce_o,
    input logic [XW-1:0]  pix_x_o,
    input logic [YW-1:0]  line_y_o,
    input logic           vbl_o,
    input logic           nmi_o,
    input logic [FCW-1:0] frame_cnt_o
);
    logic at_last;
    assign at_last = (32'(pix_x_o) == PIX - 1) && (32'(line_y_o) == LINES - 1);

    p_hold_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_ce_o |=> ($stable(pix_x_o) && $stable(line_y_o)));

    p_pos_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(pix_x_o) < PIX) && (32'(line_y_o) < LINES));

    p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pix_ce_o && at_last && !(rd_i && cpu_ce_o)) |=> vbl_o);

    p_read_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && cpu_ce_o) |=> !vbl_o);

    p_stat_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vbl_o |-> (stat_o == 8'h80));

    p_read_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vbl_o && !cpu_ce_o && !pix_ce_o) |=> vbl_o);

    p_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!nmi_en_i || !vbl_o) |-> !nmi_o);

    p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pix_ce_o && at_last) |=> $stable(frame_cnt_o));
endmodule

bind pal_frame_timer pal_frame_timer_chk #(
    .PIX(PIX_PER_LINE), .LINES(LINES), .XW(XW), .YW(YW), .FCW(FCW)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_en_i    (nmi_en_i),
    .rd_i        (rd_i),
    .stat_o      (stat_o),
    .pix_ce_o    (pix_ce_o),
    .cpu_ce_o    (cpu_ce_o),
    .pix_x_o     (pix_x_o),
    .line_y_o    (line_y_o),
    .vbl_o       (vbl_o),
    .nmi_o       (nmi_o),
    .frame_cnt_o (frame_cnt_o)
);

// File: tb/test_pal_frame_timer.sv
module test_pal_frame_timer;
    localparam int PIX  = 8;
    localparam int LN   = 3;
    localparam int NP   = PIX * LN;
    localparam int PD   = 5;
    localparam int CD   = 16;
    localparam int CLR  = 10;
    localparam int FCW  = 16;
    localparam int XW   = $clog2(PIX);
    localparam int YW   = $clog2(LN);
    localparam int PPW  = $clog2(PD);
    localparam int CPW  = $clog2(CD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PPW-1:0] pph = '0;
    logic [CPW-1:0] cph = '0;
    logic early = 1'b0, nen = 1'b0, rd = 1'b0;
    logic [7:0] stat;
    logic pce, cce, vbl, nmi, fpar;
    logic [XW-1:0] px;
    logic [YW-1:0] py;
    logic [FCW-1:0] fcnt;

    int checks = 0, errors = 0;
    int t = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) t <= rst_n ? t + 1 : 0;

    pal_frame_timer #(
        .PIX_PER_LINE(PIX), .LINES(LN), .PIX_DIV(PD), .CPU_DIV(CD),
        .CLR_PIX(CLR), .FCW(FCW)
    ) i_pal_frame_timer (
        .clk_i(clk), .rst_ni(rst_n), .pix_phase_i(pph), .cpu_phase_i(cph),
        .clr_early_i(early), .nmi_en_i(nen), .rd_i(rd), .stat_o(stat),
        .pix_ce_o(pce), .cpu_ce_o(cce), .pix_x_o(px), .line_y_o(py),
        .vbl_o(vbl), .nmi_o(nmi), .frame_par_o(fpar), .frame_cnt_o(fcnt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
        end
    endtask

    task automatic do_reset(input int p, input int c, input bit e, input bit en);
        @(negedge clk);
        rst_n = 1'b0; rd = 1'b0;
        pph = PPW'(p); cph = CPW'(c); early = e; nen = en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2: reset position, flag and counters
    task automatic t_reset();
        do_reset(0, 0, 0, 1);
        #1;
        chk(32'(px) == PIX - 1, "R2 reset x", px, PIX - 1);
        chk(32'(py) == LN - 1, "R2 reset y", py, LN - 1);
        chk(vbl == 0 && stat == 0, "R6 reset flag", {stat, vbl}, 0);
        chk(nmi == 0, "R8 reset nmi", nmi, 0);
        chk(fcnt == 0 && fpar == 0, "R9 reset count", fcnt, 0);
    endtask

    // R1 R2 R3 R4 R5 R8 R9: free run against closed-form expectations
    task automatic t_free(input int p, input int c, input bit e, input bit en, input int frames);
        int clr_eff;
        clr_eff = e ? CLR - 1 : CLR;
        do_reset(p, c, e, en);
        for (int k = 0; k < frames * NP * PD; k++) begin
            int adv, idx, sets, klast, ts, epar;
            bit eflag, epce, ecce;
            @(negedge clk); #1;
            adv   = (p + t) / PD;
            idx   = (adv == 0) ? NP - 1 : (adv - 1) % NP;
            sets  = (adv == 0) ? 0 : (adv - 1) / NP + 1;
            eflag = (adv > 0) && (idx < clr_eff);
            epce  = ((p + t) % PD) == PD - 1;
            ecce  = ((c + t) % CD) == CD - 1;
            if (sets == 0) epar = 0;
            else begin
                klast = (sets - 1) * NP + 1;
                ts    = PD * klast - p;
                epar  = ((c + ts) / CD) % 2;
            end
            chk(pce == epce && cce == ecce, "R1 enables", {pce, cce}, {epce, ecce});
            chk(32'(px) == idx % PIX && 32'(py) == idx / PIX, "R2 position",
                32'(py) * PIX + 32'(px), idx);
            chk(vbl == eflag, e ? "R5 flag early clear / R4" : "R5 flag clear / R4", vbl, eflag);
            chk(stat == ((eflag || (epce && idx == NP - 1)) ? 8'h80 : 8'h00), "R6 status",
                stat, (eflag || (epce && idx == NP - 1)) ? 128 : 0);
            chk(nmi == (eflag && en), "R8 nmi", nmi, eflag && en);
            chk(32'(fcnt) == sets, "R9 frame count", fcnt, sets);
            chk(fpar == epar[0], "R3 start parity", fpar, epar);
        end
    endtask

    // R10: four-frame parity pattern from phases 0/0
    task automatic t_parity();
        bit pat [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
        logic [FCW-1:0] last_cnt;
        int seen = 0;
        do_reset(0, 0, 0, 0);
        last_cnt = '0;
        while (seen < 8) begin
            @(negedge clk); #1;
            if (fcnt != last_cnt) begin
                chk(fpar == pat[seen % 4], "R10 parity pattern", fpar, pat[seen % 4]);
                last_cnt = fcnt;
                seen++;
            end
        end
    endtask

    // R6 R7: gated read, qualified read, flag stays clear until next start
    task automatic t_read();
        logic [FCW-1:0] c0;
        do_reset(1, 3, 0, 1);
        do begin @(negedge clk); #1; end while (!(vbl && !cce && !pce));
        rd = 1'b1; #1;
        chk(stat == 8'h80, "R6 status during blank", stat, 128);
        @(negedge clk); rd = 1'b0; #1;
        chk(vbl == 1'b1, "R7 ungated read ignored", vbl, 1);
        chk(nmi == 1'b1, "R8 nmi while flag", nmi, 1);
        do begin @(negedge clk); #1; end while (!(vbl && cce));
        rd = 1'b1; #1;
        chk(stat == 8'h80, "R6 read value", stat, 128);
        @(negedge clk); rd = 1'b0; #1;
        chk(vbl == 1'b0, "R6 read clears", vbl, 0);
        chk(nmi == 1'b0, "R8 nmi drops", nmi, 0);
        c0 = fcnt;
        forever begin
            @(negedge clk); #1;
            if (fcnt == c0) begin
                if (vbl != 1'b0) chk(0, "R6 stays clear", vbl, 0);
            end else begin
                chk(vbl == 1'b1, "R4 next frame sets", vbl, 1);
                break;
            end
        end
    endtask

    // R6: read in the same clock as the frame start
    task automatic t_coincide();
        do_reset(0, 11, 0, 1);
        #1;
        while (!(pce && cce && 32'(px) == PIX - 1 && 32'(py) == LN - 1)) begin
            @(negedge clk); #1;
        end
        rd = 1'b1; #1;
        chk(stat == 8'h80, "R6 coincident read value", stat, 128);
        @(negedge clk); rd = 1'b0; #1;
        chk(vbl == 1'b0, "R6 coincident read clears", vbl, 0);
        chk(fcnt == 1 && px == 0 && py == 0, "R9 coincident start counted", fcnt, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", t, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_free(0, 0, 0, 1, 3);
        t_free(3, 7, 1, 1, 3);
        t_free(4, 15, 0, 0, 3);
        t_free(2, 9, 1, 0, 2);
        t_parity();
        t_read();
        t_coincide();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule